// File: doc/BRIEF.md
# SPI Banked Register Command Slave

This block is a byte-oriented SPI target (mode 0: SCK idles low, MOSI is sampled on the rising edge and MISO changes on the falling edge). It is oversampled by the system clock. After chip select falls, the first byte is a command opcode. The opcode either addresses one 8-bit control register or starts a streamed transfer to or from a small packet buffer. It can also trigger a soft reset of the register state.

Addresses 0x00 to 0x1A are banked: four copies exist, and the two low bits of the control register at 0x1F choose the copy in use. Addresses 0x1B to 0x1F are shared by all banks. In bank 0, addresses 0x00 to 0x03 hold the buffer read pointer and the buffer write pointer. Both pointers advance by one after each streamed byte.

Top module: `spi_bank_slave`

## Requirements
- R1: The opcode's bits 7:5 select the operation and bits 4:0 the register address. Group 000 is register read: the register value is shifted out MSB first in the byte that follows the opcode.
- R2: Group 010 (opcode 0x40 plus address) writes the next received byte into the addressed register.
- R3: Group 100 (0x80 plus address) ORs the next received byte into the addressed register.
- R4: Group 101 (0xA0 plus address) ANDs the addressed register with the bitwise inverse of the next received byte.
- R5: Bits 1:0 of register 0x1F select which of four independent banks addresses 0x00 to 0x1A reach. Addresses 0x1B to 0x1F reach the same registers from every bank.
- R6: A read puts a 0x00 dummy byte before the data byte, giving a 3-byte transaction, in these cases: bank 2 addresses 0x00 to 0x19, bank 3 addresses 0x00 to 0x05, and bank 3 address 0x0A. Every other read takes 2 bytes.
- R7: Opcode 0x7A stores each following byte at the write pointer, then increments it. The write pointer is bank 0 address 0x02 (low byte) and 0x03 (high byte).
- R8: Opcode 0x3A returns the byte at the read pointer for each following byte. The read pointer is bank 0 address 0x00 (low) and 0x01 (high). The pointer advances once per completed byte and wraps modulo the buffer depth of 2^BUF_AW (64 by default).
- R9: Opcode 0xFF clears every register, both pointers and the bank selection to 0. Bit 0 of the status register 0x1D then reads 0 for RST_HOLD clock cycles and 1 afterwards.
- R10: A transaction starts at the falling edge of chip select. A byte cut short by chip select rising has no effect. Bytes beyond the one data byte of a write, set or clear command are ignored.
- R11: After rst_n, all registers read 0, MISO is low, and status bit 0 reads 0 until RST_HOLD cycles have passed.
- R12: Status register 0x1D is read-only. Writes, sets and clears to it change nothing.
- R13: Opcodes outside the defined set (for example 0x3B, 0x7B, 0xC0, 0xE3) and the bytes that follow them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, low outside a transaction |

## Verification
The SPI pins pass through a two-stage synchronizer plus an edge register, so a pin edge takes effect about three system clocks later. A completed byte reaches the command engine one clock after that, and the engine's reply byte is registered on the following clock. The bench drives every pin on the falling system-clock edge, with an SCK half period of six clocks. Each reply bit therefore settles well before the bench samples MISO, just ahead of its next SCK rising edge. The status-bit checks after a reset are placed by counting SPI bytes: the first read follows well inside the hold window, and the second follows a deliberate wait longer than RST_HOLD.

// File: rtl/spi_bank_pkg.sv
// Shared constants, command state type and the dummy-byte class rule for
// the SPI banked register slave.
package spi_bank_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 5;
    localparam int NUM_BANKS   = 4;
    localparam int BANK_W      = 2;
    localparam int COMMON_BASE = 27;   // first address shared by all banks
    localparam int COMMON_N    = 32 - COMMON_BASE;

    localparam logic [2:0] GRP_RREG = 3'b000;
    localparam logic [2:0] GRP_WREG = 3'b010;
    localparam logic [2:0] GRP_BSET = 3'b100;
    localparam logic [2:0] GRP_BCLR = 3'b101;

    localparam logic [7:0] OP_BUF_READ   = 8'h3A;
    localparam logic [7:0] OP_BUF_WRITE  = 8'h7A;
    localparam logic [7:0] OP_SOFT_RESET = 8'hFF;

    localparam logic [4:0] A_STATUS = 5'h1D;
    localparam logic [4:0] A_CTRL   = 5'h1F;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_DUMMY,
        ST_RD_LAST,
        ST_WREG,
        ST_BSET,
        ST_BCLR,
        ST_BUF_RD,
        ST_BUF_WR,
        ST_IGNORE
    } cmd_state_t;

    // True when a read of this bank/address returns a padding byte first.
    function automatic logic has_dummy(input logic [1:0] bank, input logic [4:0] addr);
        return ((bank == 2'd2) && (addr <= 5'h19)) ||
               ((bank == 2'd3) && ((addr <= 5'h05) || (addr == 5'h0A)));
    endfunction

endpackage

// File: rtl/spi_byte_port.sv
// Mode-0 SPI byte serializer/deserializer, oversampled by clk.
// Assumes SCK is at least several clk periods per half cycle; pins are
// synchronized by two flops and edges found with one more register.
// Delivers each completed received byte as a one-cycle rx_valid pulse and
// shifts tx_byte out MSB first starting at the falling edge after a byte.
module spi_byte_port
    import spi_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              spi_miso,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              in_frame
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [2:0]        sck_q;
    logic [1:0]        cs_q;
    logic [1:0]        mosi_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-2:0] tx_sh;
    logic              sck_rise;
    logic              sck_fall;

    assign in_frame = ~cs_q[1];
    assign sck_rise = sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] & sck_q[2];

    // Bring the SPI pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[1:0], spi_sck};
            cs_q   <= {cs_q[0], spi_cs_n};
            mosi_q <= {mosi_q[0], spi_mosi};
        end
    end

    // Shift in on SCK rise and shift out on SCK fall; drop any partial byte when CS rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            spi_miso <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else if (!in_frame) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            spi_miso <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_q[1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    rx_byte  <= {rx_sh, mosi_q[1]};
                    rx_valid <= 1'b1;
                end
            end
            if (sck_fall) begin
                if (bit_cnt == '0) begin
                    spi_miso <= tx_byte[BYTE_W-1];
                    tx_sh    <= tx_byte[BYTE_W-2:0];
                end else begin
                    spi_miso <= tx_sh[BYTE_W-2];
                    tx_sh    <= {tx_sh[BYTE_W-3:0], 1'b0};
                end
            end
        end
    end

    // A byte can only complete while chip select was low.
    assert_byte_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(in_frame));

endmodule

// File: rtl/spi_buf_mem.sv
// Packet buffer: one synchronous write port and one combinational read port.
// Assumes the caller supplies wrapped addresses; contents are not reset.
module spi_buf_mem
    import spi_bank_pkg::*;
#(
    parameter int BUF_AW = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BUF_AW-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << BUF_AW;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    // Store one streamed byte.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spi_reg_bank.sv
// Banked control register file with the buffer pointers overlaid on bank 0
// addresses 0..3, a read-only status register and the clock-ready hold
// counter. Assumes BUF_AW <= 16. Reads are combinational and all writes
// use the bank currently selected by register 0x1F.
module spi_reg_bank
    import spi_bank_pkg::*;
#(
    parameter int BUF_AW   = 6,
    parameter int RST_HOLD = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              rd_ptr_inc,
    input  logic              wr_ptr_inc,
    output logic [BUF_AW-1:0] rd_ptr,
    output logic [BUF_AW-1:0] wr_ptr,
    output logic [BANK_W-1:0] bank_sel
);
    localparam int HOLD_W   = $clog2(RST_HOLD + 1);
    localparam int BANKED_N = COMMON_BASE;

    logic [BYTE_W-1:0] banked_q [NUM_BANKS][BANKED_N];
    logic [BYTE_W-1:0] common_q [COMMON_N];
    logic [HOLD_W-1:0] hold_cnt;
    logic              clk_rdy;
    logic              is_common;
    logic              is_ptr;
    logic [2:0]        com_idx;
    logic [15:0]       rd16;
    logic [15:0]       wr16;
    logic [15:0]       ld16;

    assign is_common = reg_addr >= ADDR_W'(COMMON_BASE);
    assign com_idx   = 3'(reg_addr - ADDR_W'(COMMON_BASE));
    assign is_ptr    = !is_common && (bank_sel == '0) && (reg_addr[4:2] == 3'b000);
    assign bank_sel  = common_q[COMMON_N-1][BANK_W-1:0];
    assign clk_rdy   = (hold_cnt == '0);
    assign rd16      = 16'(rd_ptr);
    assign wr16      = 16'(wr_ptr);

    // New 16-bit pointer value when a pointer byte is written.
    always_comb begin
        ld16 = reg_addr[1] ? wr16 : rd16;
        if (reg_addr[0]) ld16[15:8] = wr_data;
        else             ld16[7:0]  = wr_data;
    end

    // Select the read value: status, common, pointer overlay or banked storage.
    always_comb begin
        if (is_common) begin
            if (reg_addr == A_STATUS) rd_data = {{(BYTE_W-1){1'b0}}, clk_rdy};
            else                      rd_data = common_q[com_idx];
        end else if (is_ptr) begin
            case (reg_addr[1:0])
                2'd0:    rd_data = rd16[7:0];
                2'd1:    rd_data = rd16[15:8];
                2'd2:    rd_data = wr16[7:0];
                default: rd_data = wr16[15:8];
            endcase
        end else begin
            rd_data = banked_q[bank_sel][reg_addr];
        end
    end

    // Register storage with reset and soft reset to zero; the status register is never written.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int b = 0; b < NUM_BANKS; b++)
                for (int i = 0; i < BANKED_N; i++)
                    banked_q[b][i] <= '0;
            for (int c = 0; c < COMMON_N; c++)
                common_q[c] <= '0;
        end else if (wr_en) begin
            if (is_common) begin
                if (reg_addr != A_STATUS) common_q[com_idx] <= wr_data;
            end else begin
                banked_q[bank_sel][reg_addr] <= wr_data;
            end
        end
    end

    // Buffer pointers: a register write loads them, a streamed byte advances them.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (wr_en && is_ptr && !reg_addr[1]) rd_ptr <= ld16[BUF_AW-1:0];
            else if (rd_ptr_inc)                 rd_ptr <= rd_ptr + 1'b1;
            if (wr_en && is_ptr && reg_addr[1])  wr_ptr <= ld16[BUF_AW-1:0];
            else if (wr_ptr_inc)                 wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Clock-ready hold window after either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)  hold_cnt <= HOLD_W'(RST_HOLD);
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    assert_rst_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !clk_rdy);

    assert_rst_bank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (bank_sel == '0));

    assert_rdptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr_inc && !soft_rst && !(wr_en && is_ptr)) |=>
            (rd_ptr == BUF_AW'($past(rd_ptr) + 1'b1)));

    assert_wrptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_inc && !soft_rst && !(wr_en && is_ptr)) |=>
            (wr_ptr == BUF_AW'($past(wr_ptr) + 1'b1)));

endmodule

// File: rtl/spi_cmd_engine.sv
// Command decoder and sequencer. Assumes one rx_valid pulse per received
// byte and that in_frame drops between transactions. Takes the opcode,
// runs register read/write/set/clear, buffer streams and soft reset, and
// prepares the next byte to shift out.
module spi_cmd_engine
    import spi_bank_pkg::*;
#(
    parameter int BUF_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_frame,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [BYTE_W-1:0] reg_rd_data,
    input  logic [BYTE_W-1:0] mem_rd_data,
    input  logic [BUF_AW-1:0] rd_ptr,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              soft_rst,
    output logic              rd_ptr_inc,
    output logic              wr_ptr_inc,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [BUF_AW-1:0] mem_raddr
);
    cmd_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        grp;

    assign grp      = rx_byte[7:5];
    assign reg_addr = (state_q == ST_IDLE) ? rx_byte[ADDR_W-1:0] : addr_q;

    // Register update strobes for write, set and clear.
    always_comb begin
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
        if (rx_valid) begin
            case (state_q)
                ST_WREG: begin reg_wr_en = 1'b1; reg_wr_data = rx_byte; end
                ST_BSET: begin reg_wr_en = 1'b1; reg_wr_data = reg_rd_data | rx_byte; end
                ST_BCLR: begin reg_wr_en = 1'b1; reg_wr_data = reg_rd_data & ~rx_byte; end
                default: ;
            endcase
        end
    end

    // Buffer and reset strobes.
    assign soft_rst   = rx_valid && (state_q == ST_IDLE) && (rx_byte == OP_SOFT_RESET);
    assign mem_we     = rx_valid && (state_q == ST_BUF_WR);
    assign mem_wdata  = rx_byte;
    assign wr_ptr_inc = mem_we;
    assign rd_ptr_inc = rx_valid && (state_q == ST_BUF_RD);
    assign mem_raddr  = rd_ptr_inc ? BUF_AW'(rd_ptr + 1'b1) : rd_ptr;

    // Command sequencing and preparation of the next outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_frame) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            tx_byte <= '0;
        end else if (rx_valid) begin
            tx_byte <= '0;
            case (state_q)
                ST_IDLE: begin
                    addr_q <= rx_byte[ADDR_W-1:0];
                    if (rx_byte == OP_BUF_READ) begin
                        state_q <= ST_BUF_RD;
                        tx_byte <= mem_rd_data;
                    end else if (rx_byte == OP_BUF_WRITE) begin
                        state_q <= ST_BUF_WR;
                    end else begin
                        case (grp)
                            GRP_RREG: begin
                                if (has_dummy(bank_sel, rx_byte[ADDR_W-1:0])) begin
                                    state_q <= ST_RD_DUMMY;
                                end else begin
                                    state_q <= ST_RD_LAST;
                                    tx_byte <= reg_rd_data;
                                end
                            end
                            GRP_WREG: state_q <= ST_WREG;
                            GRP_BSET: state_q <= ST_BSET;
                            GRP_BCLR: state_q <= ST_BCLR;
                            default:  state_q <= ST_IGNORE;
                        endcase
                    end
                end
                ST_RD_DUMMY: begin
                    state_q <= ST_RD_LAST;
                    tx_byte <= reg_rd_data;
                end
                ST_BUF_RD: tx_byte <= mem_rd_data;
                ST_BUF_WR: state_q <= ST_BUF_WR;
                default:   state_q <= ST_IGNORE;
            endcase
        end
    end

    assert_write_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> in_frame);

    assert_ignore_is_inert_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !(reg_wr_en || mem_we || rd_ptr_inc || soft_rst));

endmodule

// File: rtl/spi_bank_slave.sv
// Top level of the SPI banked register command slave: byte port, command
// engine, register bank and packet buffer. Assumes a free-running clk at
// least about eight times faster than SCK.
module spi_bank_slave
    import spi_bank_pkg::*;
#(
    parameter int BUF_AW   = 6,
    parameter int RST_HOLD = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    logic [BYTE_W-1:0] tx_byte, rx_byte, reg_rd_data, reg_wr_data;
    logic [BYTE_W-1:0] mem_rd_data, mem_wdata;
    logic              rx_valid, in_frame, reg_wr_en, soft_rst;
    logic              rd_ptr_inc, wr_ptr_inc, mem_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [BANK_W-1:0] bank_sel;
    logic [BUF_AW-1:0] rd_ptr, wr_ptr, mem_raddr;

    spi_byte_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .tx_byte  (tx_byte),
        .spi_miso (spi_miso),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .in_frame (in_frame)
    );

    spi_cmd_engine #(.BUF_AW(BUF_AW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_frame    (in_frame),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .bank_sel    (bank_sel),
        .reg_rd_data (reg_rd_data),
        .mem_rd_data (mem_rd_data),
        .rd_ptr      (rd_ptr),
        .tx_byte     (tx_byte),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .soft_rst    (soft_rst),
        .rd_ptr_inc  (rd_ptr_inc),
        .wr_ptr_inc  (wr_ptr_inc),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_raddr   (mem_raddr)
    );

    spi_reg_bank #(.BUF_AW(BUF_AW), .RST_HOLD(RST_HOLD)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .reg_addr   (reg_addr),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .rd_data    (reg_rd_data),
        .rd_ptr_inc (rd_ptr_inc),
        .wr_ptr_inc (wr_ptr_inc),
        .rd_ptr     (rd_ptr),
        .wr_ptr     (wr_ptr),
        .bank_sel   (bank_sel)
    );

    spi_buf_mem #(.BUF_AW(BUF_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_ptr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rd_data)
    );

endmodule

// File: tb/spi_bank_slave_bench.sv
module spi_bank_slave_bench;
    localparam int HALF     = 6;
    localparam int BUF_AW   = 6;
    localparam int DEPTH    = 1 << BUF_AW;
    localparam int RST_HOLD = 400;
    localparam int WD_LIMIT = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] m_bank [4][32];
    logic [7:0] m_com [5];
    int         m_rdp, m_wrp;
    logic       m_ready;
    logic [7:0] bmem [DEPTH];

    always #2.5 clk = ~clk;

    spi_bank_slave #(.BUF_AW(BUF_AW), .RST_HOLD(RST_HOLD)) u_spi_bank_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog R10 actual=timeout expected=complete");
            finish_run();
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic hclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] cur_bank();
        return m_com[4][1:0];
    endfunction

    function automatic bit is_dummy(input logic [1:0] b, input logic [4:0] a);
        return (b == 2'd2 && a <= 5'h19) || (b == 2'd3 && (a <= 5'h05 || a == 5'h0A));
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a == 5'h1D) return {7'b0, m_ready};
        if (a >= 5'h1B) return m_com[a - 5'h1B];
        if (cur_bank() == 2'd0 && a <= 5'h03) begin
            case (a[1:0])
                2'd0:    return 8'(m_rdp);
                2'd2:    return 8'(m_wrp);
                default: return 8'h00;
            endcase
        end
        return m_bank[cur_bank()][a];
    endfunction

    task automatic mwrite(input logic [4:0] a, input logic [7:0] d);
        if (a >= 5'h1B) begin
            if (a != 5'h1D) m_com[a - 5'h1B] = d;
        end else if (cur_bank() == 2'd0 && a <= 5'h03) begin
            if (a == 5'h00) m_rdp = int'(d) % DEPTH;
            if (a == 5'h02) m_wrp = int'(d) % DEPTH;
        end else begin
            m_bank[cur_bank()][a] = d;
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) m_bank[b][a] = 8'h00;
        for (int c = 0; c < 5; c++) m_com[c] = 8'h00;
        m_rdp = 0; m_wrp = 0; m_ready = 1'b0;
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0; hclk(HALF);
    endtask

    task automatic cs_high();
        hclk(HALF); spi_cs_n = 1'b1; hclk(2 * HALF);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = tx[i];
            hclk(HALF);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            hclk(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r;
        cs_low(); xbyte({3'b010, a}, r); xbyte(d, r); cs_high();
        mwrite(a, d);
    endtask

    task automatic bset_reg(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r;
        cs_low(); xbyte({3'b100, a}, r); xbyte(d, r); cs_high();
        mwrite(a, exp_read(a) | d);
    endtask

    task automatic bclr_reg(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r;
        cs_low(); xbyte({3'b101, a}, r); xbyte(d, r); cs_high();
        mwrite(a, exp_read(a) & ~d);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
        logic [7:0] d0;
        cs_low();
        xbyte({3'b000, a}, d0);
        if (is_dummy(cur_bank(), a)) begin
            xbyte(8'h00, d0);
            chk(d0, 8'h00, $sformatf("R6 dummy bank%0d addr%02h", cur_bank(), a));
        end
        xbyte(8'h00, v);
        cs_high();
    endtask

    task automatic rd_chk(input logic [4:0] a, input string tag);
        logic [7:0] v;
        rd_reg(a, v);
        chk(v, exp_read(a), tag);
    endtask

    initial begin
        logic [7:0] r;
        model_clear();
        hclk(10);
        rst_n = 1'b1;
        hclk(2);
        chk({7'b0, spi_miso}, 8'h00, "R11 miso idle low");
        // R11: status bit still low inside the hold window, registers zero
        rd_chk(5'h1D, "R11 status after reset");
        rd_chk(5'h1F, "R11 control after reset");
        rd_chk(5'h1B, "R11 common after reset");
        hclk(RST_HOLD + 50);
        m_ready = 1'b1;
        rd_chk(5'h1D, "R11 status ready after hold");

        // R1 R2 R5 R6: write all addresses of every bank, read back
        for (int b = 0; b < 4; b++) begin
            wr_reg(5'h1F, 8'(b));
            for (int a = 0; a < 31; a++) begin
                if (a != 29) wr_reg(5'(a), 8'((b * 53 + a * 29 + 7) & 8'hFF));
            end
            for (int a = 0; a < 32; a++)
                rd_chk(5'(a), $sformatf("R1 R2 bank%0d addr%02h", b, a));
        end
        // R5: banks hold independent values, common registers shared
        for (int b = 0; b < 4; b++) begin
            wr_reg(5'h1F, 8'(b));
            for (int a = 0; a < 32; a++)
                rd_chk(5'(a), $sformatf("R5 bank%0d addr%02h", b, a));
        end

        // R3 R4: set and clear bits
        wr_reg(5'h1F, 8'h01);
        wr_reg(5'h05, 8'h5A);
        bset_reg(5'h05, 8'h81);
        rd_chk(5'h05, "R3 set bits");
        chk(exp_read(5'h05), 8'hDB, "R3 model value");
        bclr_reg(5'h05, 8'h0F);
        rd_chk(5'h05, "R4 clear bits");
        chk(exp_read(5'h05), 8'hD0, "R4 model value");
        bclr_reg(5'h1F, 8'h03);
        bset_reg(5'h1F, 8'h02);
        rd_chk(5'h1F, "R3 R5 bank via set");
        rd_chk(5'h04, "R5 R6 bank2 dummy via set");

        // R12: status is read-only
        wr_reg(5'h1D, 8'h00);
        bclr_reg(5'h1D, 8'hFF);
        bset_reg(5'h1D, 8'hFE);
        rd_chk(5'h1D, "R12 status unchanged");

        // R7: buffer write with wrap
        wr_reg(5'h1F, 8'h00);
        wr_reg(5'h02, 8'h3C);
        wr_reg(5'h03, 8'h00);
        cs_low();
        xbyte(8'h7A, r);
        for (int k = 0; k < 8; k++) begin
            xbyte(8'(k * 17 + 3), r);
            bmem[(m_wrp + k) % DEPTH] = 8'(k * 17 + 3);
        end
        cs_high();
        m_wrp = (m_wrp + 8) % DEPTH;
        rd_chk(5'h02, "R7 write pointer advanced");
        rd_chk(5'h03, "R7 write pointer high");

        // R8: buffer read with wrap
        wr_reg(5'h00, 8'h3C);
        cs_low();
        xbyte(8'h3A, r);
        for (int k = 0; k < 8; k++) begin
            xbyte(8'h00, r);
            chk(r, bmem[(m_rdp + k) % DEPTH], $sformatf("R8 stream byte %0d", k));
        end
        cs_high();
        m_rdp = (m_rdp + 8) % DEPTH;
        rd_chk(5'h00, "R8 read pointer after 8");
        wr_reg(5'h00, 8'h3E);
        cs_low();
        xbyte(8'h3A, r);
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, r);
            chk(r, bmem[(m_rdp + k) % DEPTH], $sformatf("R8 short stream %0d", k));
        end
        cs_high();
        m_rdp = (m_rdp + 3) % DEPTH;
        rd_chk(5'h00, "R8 read pointer after 3 wrap");

        // R10: partial opcode and partial data byte are dropped
        wr_reg(5'h1B, 8'h66);
        cs_low(); xbits(8'h5B, 4, r); cs_high();
        rd_chk(5'h1B, "R10 partial opcode");
        cs_low(); xbyte(8'h5B, r); xbits(8'h99, 5, r); cs_high();
        rd_chk(5'h1B, "R10 partial data byte");
        cs_low(); xbyte(8'h5C, r); xbyte(8'h11, r); xbyte(8'h22, r); cs_high();
        mwrite(5'h1C, 8'h11);
        rd_chk(5'h1C, "R10 extra bytes ignored");

        // R13: undefined opcodes
        cs_low(); xbyte(8'h3B, r); xbyte(8'h77, r); cs_high();
        cs_low(); xbyte(8'h7B, r); xbyte(8'h55, r); cs_high();
        cs_low(); xbyte(8'hE3, r); xbyte(8'h44, r); cs_high();
        cs_low(); xbyte(8'hC0, r); xbyte(8'h33, r); cs_high();
        rd_chk(5'h00, "R13 read pointer unchanged");
        rd_chk(5'h02, "R13 write pointer unchanged");
        rd_chk(5'h1B, "R13 common unchanged");
        rd_chk(5'h1C, "R13 common2 unchanged");

        // R9: soft reset
        wr_reg(5'h10, 8'hA5);
        wr_reg(5'h1F, 8'h03);
        cs_low(); xbyte(8'hFF, r); cs_high();
        model_clear();
        rd_chk(5'h1D, "R9 status low after soft reset");
        rd_chk(5'h1F, "R9 bank cleared");
        rd_chk(5'h1B, "R9 common cleared");
        rd_chk(5'h00, "R9 read pointer cleared");
        rd_chk(5'h02, "R9 write pointer cleared");
        rd_chk(5'h10, "R9 banked cleared");
        hclk(RST_HOLD + 50);
        m_ready = 1'b1;
        rd_chk(5'h1D, "R9 status ready after hold");

        done = 1'b1;
        finish_run();
    end

endmodule